// File: doc/BRIEF.md
# Lockable Raster Timing Generator

This block produces the horizontal and vertical timing strobes of a display raster: sync, blanking, active-video and a clock-enable window on each axis. A pixel-rate down-counter runs from a programmed horizontal total to zero and reloads, and each time it reaches zero it steps a line-rate down-counter that behaves the same way against a vertical total. Each strobe is the output of a window comparator whose start and stop counts are packed into a single register word.

The timing registers are guarded against stray writes. A write only lands if the bus access just before it was the key value 0xAA written to the lock register. The key opens the gate for one access and no more, and a read also closes the gate. Bit 0 of the attribute register starts the raster. While that bit is clear both counters sit at their totals and every strobe is held low.

Software programs the totals as (active + front porch + back porch + sync) minus one. It sets sync start to the total and sync stop to the total minus the sync length. It sets active start to total minus sync minus back porch and active stop to front porch minus one. The blank window uses the same pair as the active window.

Top module: `raster_timing_gen`

## Requirements
- R1: A horizontal strobe is high exactly when the enable is set and hcount <= start and hcount > stop, where start is bits 15:0 and stop is bits 31:16 of its window register.
- R2: While enabled, hcount decrements by one every clock and reloads to the horizontal total in the clock after it is zero, so one line lasts total+1 clocks.
- R3: While enabled, vcount changes only in the clock after hcount is zero: it decrements by one, or reloads to the vertical total if it was zero.
- R4: A vertical strobe follows the R1 rule applied to vcount and its own window register.
- R5: A write of 0xAA to the lock register (word address 12) opens the gate, and a protected write in the access immediately after the key takes effect.
- R6: A write to a protected register with the gate closed leaves that register unchanged.
- R7: Any bus access other than a key write closes the gate, so a protected write after the key and one intervening read or write is ignored, and a second write after one key is ignored.
- R8: With attribute bit 0 (word address 10) clear, all eight strobes are low and hcount and vcount hold their totals from the second clock after the bit is cleared.
- R9: After reset all registers read zero, the gate is closed, the counters are zero and all strobes are low.
- R10: Reading the lock register returns the gate state in bit 0 (1 = open).
- R11: Word addresses: 0 horizontal total, 1 to 4 horizontal sync, blank, active and clock windows, 5 vertical total, 6 to 9 vertical sync, blank, active and clock windows, 10 attribute, 11 line carry, 12 lock. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| hcount | output | 16 | Horizontal down-counter |
| vcount | output | 16 | Vertical down-counter |
| hsync | output | 1 | Horizontal sync window |
| hblank | output | 1 | Horizontal blank window |
| hactive | output | 1 | Horizontal active window |
| hclk_en | output | 1 | Horizontal clock window |
| vsync | output | 1 | Vertical sync window |
| vblank | output | 1 | Vertical blank window |
| vactive | output | 1 | Vertical active window |
| vclk_en | output | 1 | Vertical clock window |

## Verification
The bench sets window pairs at the edges of the window rule: start above the total, start equal to stop, start below stop, and a window that spans the whole line. If a comparator used the wrong inclusive or exclusive bound, each line would have one strobe cycle too many or too few. For the gate, the bench tries a write with no key, a key followed by a read, a key followed by a non-key write to the lock register, and two writes after one key. A gate that stayed open for more than one access would let the later write change the read-back value. The bench also checks the vertical step at the horizontal wrap and the held counters after disable, which shows an off-by-one line period or a missing reload.

// File: rtl/rtg_pkg.sv
// Package: shared constants and types for the raster timing generator.
// Assumes 16-bit counts so that a start/stop pair fills one 32-bit word.
package rtg_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 16;
    localparam int NUM_WIN = 4;

    // Window order within each axis group.
    localparam int WIN_SYNC   = 0;
    localparam int WIN_BLANK  = 1;
    localparam int WIN_ACTIVE = 2;
    localparam int WIN_CLK    = 3;

    // Word address map.
    localparam logic [ADDR_W-1:0] A_HTOTAL = 4'd0;
    localparam int                A_HWIN0  = 1;
    localparam logic [ADDR_W-1:0] A_VTOTAL = 4'd5;
    localparam int                A_VWIN0  = 6;
    localparam logic [ADDR_W-1:0] A_ATTR   = 4'd10;
    localparam logic [ADDR_W-1:0] A_CARRY  = 4'd11;
    localparam logic [ADDR_W-1:0] A_LOCK   = 4'd12;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_00AA;

    // Window pair: stop in the upper half, start in the lower half.
    typedef struct packed {
        logic [CNT_W-1:0] stop;
        logic [CNT_W-1:0] start;
    } win_t;
endpackage

// File: rtl/rtg_lock_gate.sv
// Module: single-access write gate for the protected register file.
// A key write opens the gate; the next access of any kind closes it.
// Assumes at most one bus access per clock.
module rtg_lock_gate
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              gate_open,
    output logic              wr_accept
);
    logic key_seen;

    assign key_seen  = acc_valid && acc_we && (acc_addr == A_LOCK) && (acc_wdata == UNLOCK_KEY);
    assign wr_accept = acc_valid && acc_we && gate_open && (acc_addr != A_LOCK);

    // Gate state: set by a key write, cleared by every other access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_open <= 1'b0;
        else if (acc_valid)
            gate_open <= key_seen;
    end
endmodule

// File: rtl/rtg_regs.sv
// Module: protected timing register file with combinational read-back.
// Assumes writes arrive pre-qualified by the lock gate.
module rtg_regs
    import rtg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic                    gate_open,
    output logic [DATA_W-1:0]       rdata,
    output logic [CNT_W-1:0]        htotal,
    output logic [CNT_W-1:0]        vtotal,
    output win_t [NUM_WIN-1:0]      hwin,
    output win_t [NUM_WIN-1:0]      vwin,
    output logic                    enable
);
    logic [DATA_W-1:0] attr_q;
    logic [DATA_W-1:0] carry_q;

    assign enable = attr_q[0];

    // Horizontal and vertical totals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htotal <= '0;
            vtotal <= '0;
        end else if (wr_en) begin
            if (addr == A_HTOTAL) htotal <= wdata[CNT_W-1:0];
            if (addr == A_VTOTAL) vtotal <= wdata[CNT_W-1:0];
        end
    end

    // Attribute and line-carry words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q  <= '0;
            carry_q <= '0;
        end else if (wr_en) begin
            if (addr == A_ATTR)  attr_q  <= wdata;
            if (addr == A_CARRY) carry_q <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        // Window pair i of each axis.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hwin[i] <= '0;
                vwin[i] <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(A_HWIN0 + i)) hwin[i] <= win_t'(wdata);
                if (addr == ADDR_W'(A_VWIN0 + i)) vwin[i] <= win_t'(wdata);
            end
        end
    end

    // Read-back multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_HTOTAL:                   rdata = DATA_W'(htotal);
            A_VTOTAL:                   rdata = DATA_W'(vtotal);
            A_ATTR:                     rdata = attr_q;
            A_CARRY:                    rdata = carry_q;
            A_LOCK:                     rdata = DATA_W'(gate_open);
            4'd1, 4'd2, 4'd3, 4'd4:     rdata = DATA_W'(hwin[addr - 4'd1]);
            4'd6, 4'd7, 4'd8, 4'd9:     rdata = DATA_W'(vwin[addr - 4'd6]);
            default:                    rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtg_axis_counter.sv
// Module: down-counter for one raster axis.
// Holds the total while stopped; counts down on step and reloads after zero.
module rtg_axis_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = run && step && (count == '0);

    // Count down, reload after zero, park at the total when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (!run)
            count <= total;
        else if (step)
            count <= (count == '0) ? total : count - 1'b1;
    end
endmodule

// File: rtl/rtg_window_cmp.sv
// Module: window comparator, high while stop < count <= start and enabled.
module rtg_window_cmp
    import rtg_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  win_t             win,
    input  logic             en,
    output logic             hit
);
    assign hit = en && (count <= win.start) && (count > win.stop);
endmodule

// File: rtl/raster_timing_gen.sv
// Module: top of the raster timing generator.
// Ties the lock gate, register file, two axis counters and eight window
// comparators together. One bus access per cycle; reads are combinational.
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [15:0]       hcount,
    output logic [15:0]       vcount,
    output logic              hsync,
    output logic              hblank,
    output logic              hactive,
    output logic              hclk_en,
    output logic              vsync,
    output logic              vblank,
    output logic              vactive,
    output logic              vclk_en
);
    logic               unlocked;
    logic               wr_ok;
    logic [CNT_W-1:0]   htotal;
    logic [CNT_W-1:0]   vtotal;
    win_t [NUM_WIN-1:0] hwin;
    win_t [NUM_WIN-1:0] vwin;
    logic               enable;
    logic               h_wrap;
    logic               v_wrap;
    logic [NUM_WIN-1:0] hw;
    logic [NUM_WIN-1:0] vw;

    rtg_lock_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .acc_we    (bus_we),
        .acc_addr  (bus_addr),
        .acc_wdata (bus_wdata),
        .gate_open (unlocked),
        .wr_accept (wr_ok)
    );

    rtg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .gate_open (unlocked),
        .rdata     (bus_rdata),
        .htotal    (htotal),
        .vtotal    (vtotal),
        .hwin      (hwin),
        .vwin      (vwin),
        .enable    (enable)
    );

    rtg_axis_counter #(.CNT_W(CNT_W)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .step  (1'b1),
        .total (htotal),
        .count (hcount),
        .wrap  (h_wrap)
    );

    rtg_axis_counter #(.CNT_W(CNT_W)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .step  (h_wrap),
        .total (vtotal),
        .count (vcount),
        .wrap  (v_wrap)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        rtg_window_cmp u_hcmp (.count(hcount), .win(hwin[i]), .en(enable), .hit(hw[i]));
        rtg_window_cmp u_vcmp (.count(vcount), .win(vwin[i]), .en(enable), .hit(vw[i]));
    end

    assign hsync   = hw[WIN_SYNC];
    assign hblank  = hw[WIN_BLANK];
    assign hactive = hw[WIN_ACTIVE];
    assign hclk_en = hw[WIN_CLK];
    assign vsync   = vw[WIN_SYNC];
    assign vblank  = vw[WIN_BLANK];
    assign vactive = vw[WIN_ACTIVE];
    assign vclk_en = vw[WIN_CLK];
endmodule

// Module: assertion checker for raster_timing_gen, attached by bind.
module rtg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic        bus_we,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        unlocked,
    input logic [15:0] htotal,
    input logic        enable,
    input logic [15:0] hcount,
    input logic [15:0] vcount,
    input logic [3:0]  hw,
    input logic [3:0]  vw
);
    logic key_wr;
    assign key_wr = bus_valid && bus_we && (bus_addr == 4'd12) && (bus_wdata == 32'hAA);

    assert_hcount_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hcount != 16'd0) |=> (hcount == $past(hcount) - 16'd1));

    assert_hcount_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount == 16'd0) |=> (hcount == $past(htotal)));

    assert_vcount_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hcount != 16'd0) |=> $stable(vcount));

    assert_key_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> unlocked);

    assert_locked_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && bus_addr == 4'd0 && !unlocked) |=> $stable(htotal));

    assert_access_relocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !key_wr) |=> !unlocked);

    assert_disabled_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (hw == 4'd0 && vw == 4'd0));
endmodule

bind raster_timing_gen rtg_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .unlocked  (unlocked),
    .htotal    (htotal),
    .enable    (enable),
    .hcount    (hcount),
    .vcount    (vcount),
    .hw        (hw),
    .vw        (vw)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] hcount, vcount;
    logic        hsync, hblank, hactive, hclk_en, vsync, vblank, vactive, vclk_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    raster_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hcount(hcount), .vcount(vcount), .hsync(hsync), .hblank(hblank),
        .hactive(hactive), .hclk_en(hclk_en), .vsync(vsync), .vblank(vblank),
        .vactive(vactive), .vclk_en(vclk_en)
    );

    // Entries: {total, start, stop, expected hsync cycles per line}.
    localparam logic [63:0] TBL [7] = '{
        {16'd9,  16'd9,  16'd6, 16'd3},
        {16'd9,  16'd5,  16'd2, 16'd3},
        {16'd9,  16'd3,  16'd3, 16'd0},
        {16'd9,  16'd12, 16'd7, 16'd2},
        {16'd15, 16'd15, 16'd0, 16'd15},
        {16'd4,  16'd4,  16'd1, 16'd3},
        {16'd7,  16'd2,  16'd5, 16'd0}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pwr(input logic [3:0] a, input logic [31:0] d);
        wr(4'd12, 32'hAA);
        wr(a, d);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state.
        check(hcount == 0 && vcount == 0, "R9 counters", hcount, 0);
        check({hsync, hblank, hactive, hclk_en, vsync, vblank, vactive, vclk_en} == 8'd0,
              "R9 strobes", {hsync, vsync}, 0);
        rd(4'd0, d);  check(d == 0, "R9 htotal reads zero", d, 0);
        rd(4'd12, d); check(d == 0, "R9 R10 gate closed", d, 0);

        // R6: write without key ignored.
        wr(4'd0, 32'd9);
        rd(4'd0, d); check(d == 0, "R6 unkeyed write", d, 0);

        // R5: keyed write lands.
        pwr(4'd0, 32'd9);
        rd(4'd0, d); check(d == 9, "R5 keyed write", d, 9);

        // R7: a read after the key closes the gate.
        wr(4'd12, 32'hAA);
        rd(4'd10, d);
        wr(4'd0, 32'd5);
        rd(4'd0, d); check(d == 9, "R7 read relocks", d, 9);

        // R7: a non-key write to the lock register closes the gate.
        wr(4'd12, 32'hAA);
        wr(4'd12, 32'h55);
        wr(4'd0, 32'd5);
        rd(4'd0, d); check(d == 9, "R7 nonkey lock write relocks", d, 9);

        // R7: one key admits one write only.
        pwr(4'd0, 32'd7);
        wr(4'd0, 32'd3);
        rd(4'd0, d); check(d == 7, "R7 second write ignored", d, 7);

        // R10: lock readback shows the open gate.
        wr(4'd12, 32'hAA);
        rd(4'd12, d); check(d == 1, "R10 gate open readback", d, 1);
        rd(4'd12, d); check(d == 0, "R10 gate closed after read", d, 0);

        // R1: table of horizontal windows.
        for (int e = 0; e < 7; e++) begin
            logic [15:0] tot, st, sp, expn;
            int cnt;
            bit rel_ok;
            {tot, st, sp, expn} = TBL[e];
            pwr(4'd10, 32'd0);
            pwr(4'd0, {16'd0, tot});
            pwr(4'd1, {sp, st});
            pwr(4'd10, 32'd1);
            repeat (2) @(negedge clk);
            cnt = 0; rel_ok = 1'b1;
            for (int c = 0; c <= int'(tot); c++) begin
                if (hsync) cnt++;
                if (hsync != (hcount <= st && hcount > sp)) rel_ok = 1'b0;
                @(negedge clk);
            end
            check(cnt == int'(expn), "R1 hsync cycles per line", cnt, expn);
            check(rel_ok, "R1 hsync window rule", 0, 1);
        end

        // R2 R3 R4: counting and the vertical window.
        pwr(4'd10, 32'd0);
        pwr(4'd0, 32'd9);
        pwr(4'd5, 32'd3);
        pwr(4'd6, {16'd1, 16'd3});
        pwr(4'd10, 32'd1);
        repeat (2) @(negedge clk);
        begin
            logic [15:0] ph, pv;
            bit h_ok, v_ok, w_ok;
            int last9, period;
            h_ok = 1; v_ok = 1; w_ok = 1; last9 = -1; period = -1;
            ph = hcount; pv = vcount;
            for (int c = 1; c < 120; c++) begin
                @(negedge clk);
                if (hcount != ((ph == 0) ? 16'd9 : ph - 16'd1)) h_ok = 0;
                if (ph == 0) begin
                    if (vcount != ((pv == 0) ? 16'd3 : pv - 16'd1)) v_ok = 0;
                end else if (vcount != pv) v_ok = 0;
                if (vsync != (vcount <= 3 && vcount > 1)) w_ok = 0;
                if (hcount == 9) begin
                    if (last9 >= 0) period = c - last9;
                    last9 = c;
                end
                ph = hcount; pv = vcount;
            end
            check(h_ok, "R2 hcount sequence", 0, 1);
            check(period == 10, "R2 line period", period, 10);
            check(v_ok, "R3 vcount steps at line wrap", 0, 1);
            check(w_ok, "R4 vsync window rule", 0, 1);
        end

        // R8: disable holds counters and blanks strobes.
        wr(4'd12, 32'hAA);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = 4'd10; bus_wdata = 32'd0;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        check({hsync, hblank, hactive, hclk_en, vsync, vblank, vactive, vclk_en} == 8'd0,
              "R8 strobes low", {hsync, vsync}, 0);
        @(negedge clk);
        check(hcount == 9 && vcount == 3, "R8 counters at totals", {hcount, vcount}, {16'd9, 16'd3});
        repeat (5) @(negedge clk);
        check(hcount == 9 && vcount == 3, "R8 counters held", {hcount, vcount}, {16'd9, 16'd3});

        // R11: a vertical window address reads back its pair.
        rd(4'd6, d); check(d == {16'd1, 16'd3}, "R11 vsync window readback", d, {16'd1, 16'd3});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule